// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single timer channel built around a 16-bit up-counter. Software reaches it through a word-wide register port that holds four registers: two compare values, the counter itself and a configuration word. The counter advances on a clock-enable tick chosen from a slow and a fast source. A power-of-two prescaler divides that tick. Counting can also be gated by a stop request and by an external enable input.

Each of the two comparators has its own mode: off, match on equality, or match when the count is greater than or equal to the compare value. A fourth mode, event mode, is greater-or-equal plus an interrupt. When comparator 2 is in event mode, a match also sends the counter back to zero, so the channel produces a periodic tick whose length is set by compare value 2. Each comparator has a registered pulse output and a sticky status flag that is cleared by writing 1 to it. The low part of the configuration word can be written only once after reset. The counter can also be read with its bit order reversed.

Top module: `gp_timer`

## Requirements
- R1: After reset, all four registers read 0, the counter does not move, and `cmp1_out`, `cmp2_out` and `irq` are low.
- R2: Register addresses are 0 for compare value 1, 1 for compare value 2, 2 for the counter and 3 for the configuration word. A write takes effect at the clock edge, and reads are combinational from `reg_addr`.
- R3: Configuration bits 11:0 (11 stop-gate enable, 10 external-gate enable, 9:8 comparator-2 mode, 7:6 comparator-1 mode, 5 reverse read, 4 fast-tick select, 3:0 prescale exponent) accept only the first configuration write after reset, and later writes leave them unchanged. Bit 12 is read-only and reads 1 from that first write onward.
- R4: Configuration bit 15 is always writable. When it is 1 the counter runs, and when it is 0 the counter holds its value.
- R5: Bit 4 set to 0 selects `slow_tick` and set to 1 selects `fast_tick`. With exponent n, the counter advances once per 2^n selected ticks.
- R6: A write to the counter loads the written value, takes priority over an advance in the same cycle, and restarts the prescaler.
- R7: Mode codes are 00 off, 01 equal, 10 greater-or-equal, and 11 event (greater-or-equal plus interrupt). On each advance, a comparator whose mode matches the current count drives its output high for exactly the next clock cycle. A comparator in mode 00 never pulses.
- R8: A match sets that comparator's status flag (bit 13 for comparator 1, bit 14 for comparator 2). The flag stays set until a configuration write carries 1 in that bit. Writing 0 there leaves it unchanged.
- R9: With comparator 2 in event mode, an advance that finds the count at or above compare value 2 loads 0 instead of count+1, so the period is compare value 2 + 1 advances.
- R10: `irq` is high exactly while the comparator-2 status flag is set and comparator 2 is in event mode. It falls in the cycle after the write-1 clear.
- R11: With bit 5 set, counter reads return the bit-reversed count. Counting itself is unchanged.
- R12: With bit 11 set, a high `stop_req` freezes the counter. With bit 10 set, the counter runs only while `ext_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow clock-enable tick |
| fast_tick | input | 1 | Fast clock-enable tick |
| stop_req | input | 1 | Sleep/stop request |
| ext_en | input | 1 | External count enable |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cmp1_out | output | 1 | Comparator 1 match pulse |
| cmp2_out | output | 1 | Comparator 2 match pulse |
| irq | output | 1 | Level interrupt from comparator 2 event mode |

## Verification
The bound checker watches, on every cycle, the counter's step behaviour: hold while disabled, +1 per advance, and return to zero on an event-mode wrap. It also checks that the write-once bits stay frozen after the lock, and that match pulses and rising interrupts only follow an advance. The bench scenarios are needed for what depends on sequences of register accesses and tick patterns. These are the exact period length, the prescale ratio, clock selection, the stop and external gates, the reversed read view, and the write-1-clear and write-0-keep behaviour of the status flags.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int EXP_W     = 4;
    localparam int PRE_W     = (1 << EXP_W) - 1;
    localparam int LOW_CFG_W = 12;
    localparam int NUM_CMP   = 2;

    localparam logic [ADDR_W-1:0] ADR_CMP1  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CMP2  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CFG   = 2'd3;

    // bit positions inside the configuration word
    localparam int B_RUN    = 15;
    localparam int B_STAT1  = 13;
    localparam int B_LOCKED = 12;
    localparam int B_MODE1  = 6;

    typedef enum logic [1:0] {
        CMP_OFF = 2'b00,
        CMP_EQ  = 2'b01,
        CMP_GE  = 2'b10,
        CMP_EVT = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic             stop_gate;
        logic             ext_gate;
        cmp_mode_e        mode2;
        cmp_mode_e        mode1;
        logic             rev_read;
        logic             fast_sel;
        logic [EXP_W-1:0] pre_exp;
    } low_cfg_t;

    function automatic logic [DATA_W-1:0] bit_reverse(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    function automatic logic mode_match(input cmp_mode_e mode,
                                        input logic [DATA_W-1:0] count,
                                        input logic [DATA_W-1:0] ref_val);
        logic m;
        case (mode)
            CMP_OFF: m = 1'b0;
            CMP_EQ:  m = (count == ref_val);
            default: m = (count >= ref_val);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int EXP_W = 4,
    localparam int PW   = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             advance
);
    logic [PW-1:0] div_q;
    logic [PW-1:0] mask;
    logic [PW-1:0] all_ones;

    always_comb begin
        all_ones = '1;
        mask     = ~(all_ones << exp_sel);
        advance  = run && tick_in && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (advance) begin
            div_q <= '0;
        end else if (run && tick_in) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpt_comparator.sv
module gpt_comparator
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  cmp_mode_e    mode,
    input  logic [W-1:0] count,
    input  logic [W-1:0] ref_val,
    input  logic         clear_req,
    output logic         hit_now,
    output logic         pulse,
    output logic         status
);
    always_comb begin
        hit_now = advance && mode_match(mode, count, ref_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse  <= 1'b0;
            status <= 1'b0;
        end else begin
            pulse <= hit_now;
            if (hit_now) begin
                status <= 1'b1;
            end else if (clear_req) begin
                status <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpt_cfg_reg.sv
module gpt_cfg_reg
    import gpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic                 run_in,
    input  logic [LOW_CFG_W-1:0] low_in,
    output logic                 run_en,
    output logic                 locked,
    output low_cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            locked <= 1'b0;
            cfg    <= '0;
        end else if (wr) begin
            run_en <= run_in;
            locked <= 1'b1;
            if (!locked) begin
                cfg <= low_cfg_t'(low_in);
            end
        end
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              stop_req,
    input  logic              ext_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cmp1_out,
    output logic              cmp2_out,
    output logic              irq
);
    logic              wr_cfg, wr_cnt;
    logic              run_en, locked, run, sel_tick, adv, wrap;
    low_cfg_t          cfg;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cmp_q  [NUM_CMP];
    cmp_mode_e         mode_v [NUM_CMP];
    logic [NUM_CMP-1:0] hit_v, pulse_v, stat_v, clr_v;
    logic              unused_ro_bit;

    assign wr_cfg        = reg_wr && (reg_addr == ADR_CFG);
    assign wr_cnt        = reg_wr && (reg_addr == ADR_COUNT);
    assign unused_ro_bit = reg_wdata[B_LOCKED];

    gpt_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_cfg),
        .run_in (reg_wdata[B_RUN]),
        .low_in (reg_wdata[LOW_CFG_W-1:0]),
        .run_en (run_en),
        .locked (locked),
        .cfg    (cfg)
    );

    always_comb begin
        sel_tick = cfg.fast_sel ? fast_tick : slow_tick;
        run      = run_en
                && !(cfg.stop_gate && stop_req)
                && (!cfg.ext_gate || ext_en);
    end

    gpt_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick_in (sel_tick),
        .run     (run),
        .restart (wr_cnt),
        .exp_sel (cfg.pre_exp),
        .advance (adv)
    );

    assign mode_v[0] = cfg.mode1;
    assign mode_v[1] = cfg.mode2;

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[k] <= '0;
            end else if (reg_wr && (reg_addr == ADR_CMP1 + ADDR_W'(k))) begin
                cmp_q[k] <= reg_wdata;
            end
        end

        assign clr_v[k] = wr_cfg && reg_wdata[B_STAT1 + k];

        gpt_comparator #(.W(DATA_W)) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .advance   (adv),
            .mode      (mode_v[k]),
            .count     (cnt_q),
            .ref_val   (cmp_q[k]),
            .clear_req (clr_v[k]),
            .hit_now   (hit_v[k]),
            .pulse     (pulse_v[k]),
            .status    (stat_v[k])
        );
    end

    assign wrap = hit_v[1] && (cfg.mode2 == CMP_EVT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= reg_wdata;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            ADR_CMP1:  reg_rdata = cmp_q[0];
            ADR_CMP2:  reg_rdata = cmp_q[1];
            ADR_COUNT: reg_rdata = cfg.rev_read ? bit_reverse(cnt_q) : cnt_q;
            default:   reg_rdata = {run_en, stat_v[1], stat_v[0], locked, cfg};
        endcase
    end

    assign cmp1_out = pulse_v[0];
    assign cmp2_out = pulse_v[1];
    assign irq      = stat_v[1] && (cfg.mode2 == CMP_EVT);

endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cnt,
    input logic        adv,
    input logic        cnt_wr,
    input logic        run_en,
    input logic [1:0]  mode2,
    input logic [15:0] ref2,
    input logic        locked,
    input logic [11:0] low_cfg,
    input logic        irq,
    input logic        cmp1_out,
    input logic        cmp2_out
);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_wr) |=> $stable(cnt));

    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && !cnt_wr && mode2 == 2'b11 && cnt >= ref2) |=> (cnt == 16'd0));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !cnt_wr && !(mode2 == 2'b11 && cnt >= ref2))
        |=> (cnt == $past(cnt) + 16'd1));

    p_lock_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(low_cfg));

    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp1_out || cmp2_out) |-> $past(adv));

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(adv));
endmodule

bind gp_timer gp_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .adv      (adv),
    .cnt_wr   (wr_cnt),
    .run_en   (run_en),
    .mode2    (cfg.mode2),
    .ref2     (cmp_q[1]),
    .locked   (locked),
    .low_cfg  (cfg),
    .irq      (irq),
    .cmp1_out (cmp1_out),
    .cmp2_out (cmp2_out)
);

// File: tb/gp_timer_test.sv
`timescale 1ns/1ps
module gp_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0, fast_tick = 1'b1, stop_req = 1'b0, ext_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        cmp1_out, cmp2_out, irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gp_timer uut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .stop_req(stop_req), .ext_en(ext_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp1_out(cmp1_out), .cmp2_out(cmp2_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; reg_wr = 1'b0; stop_req = 1'b0; ext_en = 1'b0;
        slow_tick = 1'b0; fast_tick = 1'b1;
        cyc(2);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 outputs after reset", {cmp1_out, cmp2_out, irq}, 0);
        cyc(3);
        rd(2'd2, v);
        chk("R1 counter idle", v, 0);
    endtask

    task automatic t_regs_lock();
        int v;
        do_reset();
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'hBEEF);
        rd(2'd0, v); chk("R2 compare1 readback", v, 16'h1234);
        rd(2'd1, v); chk("R2 compare2 readback", v, 16'hBEEF);
        wr(2'd3, 16'h0010);
        rd(2'd3, v); chk("R3 first cfg write", v, 16'h1010);
        wr(2'd3, 16'h0FE5);
        rd(2'd3, v); chk("R3 later low bits ignored", v, 16'h1010);
        wr(2'd3, 16'h8000);
        rd(2'd3, v); chk("R4 enable writable after lock", v, 16'h9010);
    endtask

    task automatic t_run_hold();
        int a, b;
        do_reset();
        wr(2'd3, 16'h8010);
        rd(2'd2, a); cyc(3); rd(2'd2, b);
        chk("R4 counting", b - a, 3);
        chk("R7 off mode no pulse", cmp1_out | cmp2_out, 0);
        wr(2'd3, 16'h0000);
        rd(2'd2, a); cyc(4); rd(2'd2, b);
        chk("R4 hold when disabled", b, a);
        wr(2'd3, 16'h8000);
        rd(2'd2, a); cyc(3); rd(2'd2, b);
        chk("R4 resume", b - a, 3);
    endtask

    task automatic t_clock_sel();
        int a, b;
        do_reset();
        wr(2'd3, 16'h8000);
        rd(2'd2, a); cyc(4); rd(2'd2, b);
        chk("R5 slow selected, no slow ticks", b - a, 0);
        slow_tick = 1'b1;
        rd(2'd2, a); cyc(4); rd(2'd2, b);
        chk("R5 slow ticks counted", b - a, 4);
        do_reset();
        wr(2'd3, 16'h8013);
        rd(2'd2, a); cyc(16); rd(2'd2, b);
        chk("R5 prescale 2^3", b - a, 2);
    endtask

    task automatic t_cnt_write();
        int v;
        do_reset();
        wr(2'd3, 16'h8010);
        cyc(2);
        wr(2'd2, 16'd100);
        rd(2'd2, v); chk("R6 counter load wins", v, 100);
        cyc(2);
        rd(2'd2, v); chk("R6 counts from loaded value", v, 102);
        wr(2'd2, 16'd0);
        rd(2'd2, v); chk("R6 restart at zero", v, 0);
    endtask

    task automatic t_cmp_modes();
        int n, v, all;
        do_reset();
        wr(2'd0, 16'd3);
        wr(2'd3, 16'h8050);
        n = 0;
        for (int i = 0; i < 14; i++) begin
            cyc(1);
            n += cmp1_out;
        end
        chk("R7 equal mode single pulse", n, 1);
        rd(2'd3, v);
        chk("R8 status1 set", (v >> 13) & 1, 1);
        chk("R10 no irq from comparator 1", irq, 0);
        wr(2'd3, 16'h0000);
        rd(2'd3, v);
        chk("R8 write 0 keeps status1", (v >> 13) & 1, 1);
        wr(2'd3, 16'h2000);
        rd(2'd3, v);
        chk("R8 write 1 clears status1", (v >> 13) & 1, 0);
        do_reset();
        wr(2'd0, 16'd3);
        wr(2'd3, 16'h8090);
        cyc(8);
        all = 1;
        for (int i = 0; i < 4; i++) begin
            all &= cmp1_out;
            cyc(1);
        end
        chk("R7 ge mode pulses every tick", all, 1);
    endtask

    task automatic t_periodic();
        int n, v;
        do_reset();
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'hE310);
        n = 0;
        while (!cmp2_out && n < 20) begin cyc(1); n++; end
        n = 0;
        cyc(1);
        while (!cmp2_out && n < 20) begin cyc(1); n++; end
        chk("R9 period = compare2 + 1", n + 1, 5);
        chk("R10 irq asserted", irq, 1);
        wr(2'd3, 16'h0000);
        chk("R8 write 0 keeps status2 irq", irq, 1);
        rd(2'd3, v);
        chk("R8 status2 still set", (v >> 14) & 1, 1);
        wr(2'd3, 16'h4000);
        chk("R10 irq drops after clear", irq, 0);
    endtask

    task automatic t_reverse();
        int v;
        do_reset();
        wr(2'd3, 16'h0020);
        wr(2'd2, 16'h0001);
        rd(2'd2, v); chk("R11 reversed read 1", v, 16'h8000);
        wr(2'd2, 16'h00F0);
        rd(2'd2, v); chk("R11 reversed read F0", v, 16'h0F00);
    endtask

    task automatic t_gates();
        int a, b;
        do_reset();
        wr(2'd3, 16'h8810);
        stop_req = 1'b1;
        cyc(1);
        rd(2'd2, a); cyc(4); rd(2'd2, b);
        chk("R12 stop freezes", b - a, 0);
        stop_req = 1'b0;
        rd(2'd2, a); cyc(3); rd(2'd2, b);
        chk("R12 runs after stop", b - a, 3);
        do_reset();
        wr(2'd3, 16'h8410);
        rd(2'd2, a); cyc(4); rd(2'd2, b);
        chk("R12 ext gate low holds", b - a, 0);
        ext_en = 1'b1;
        rd(2'd2, a); cyc(3); rd(2'd2, b);
        chk("R12 ext gate high runs", b - a, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_regs_lock();
        t_run_hold();
        t_clock_sel();
        t_cnt_write();
        t_cmp_modes();
        t_periodic();
        t_reverse();
        t_gates();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule